// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-side register file of a PC-style parallel printer port. A byte-wide bus reaches three registers: data at offset 0, status at offset 1 and control at offset 2. The block drives the eight data pins and their shared output enable, the four handshake control pins and an interrupt request. It samples five peripheral status lines through a two-flop synchronizer.

A direction bit in the control register turns the data drivers off. While it is set, a read of the data offset returns the synchronized levels on the data pins rather than the written latch, so the port can read bytes from a peripheral. An interrupt-enable bit, also in the control register, lets a falling edge on the acknowledge line raise a level interrupt. That interrupt stays high until software reads the status register.

Top module: `pport_regs`

## Requirements
- R1: Offset 0 selects data, offset 1 status and offset 2 control, all 8 bits wide. A read of offset 3 returns 0x00 and a write to it changes no register or pin. `rdata_o` is 0x00 whenever no read is in progress.
- R2: After reset, control reads 0x0C, data reads 0x00, `pd_oe_o` is 1, `irq_o` is 0 and `ctl_o` is 4'b0111.
- R3: With control bit 5 at 0, a write to offset 0 appears on `pd_o` after the write clock edge, `pd_oe_o` is 1, and a read of offset 0 returns the written byte (0xAA and 0x55 included).
- R4: With control bit 5 at 1, `pd_oe_o` is 0 and a read of offset 0 returns the `pd_i` levels from two clock edges earlier. `pd_o` keeps the latched byte.
- R5: Control bits 3:0 read back exactly as written (0x0C and 0x0E included). They drive the pins as `ctl_o[0]` = NOT bit 0 (strobe), `ctl_o[1]` = NOT bit 1 (auto line feed), `ctl_o[2]` = bit 2 (initialise) and `ctl_o[3]` = NOT bit 3 (select-in).
- R6: Control bits 7:6 always read 0, and their written value affects no pin and no behaviour.
- R7: Status bits are: bit 7 = NOT busy, bit 6 = ack, bit 5 = paper-out, bit 4 = select, bit 3 = error, bits 2:1 = 1 and bit 0 = 0. A pin change is visible in a read after two clock edges.
- R8: With control bit 4 at 1, a falling edge on `ack_i` raises `irq_o` on the third rising clock edge after the pin falls.
- R9: With control bit 4 at 0, a falling edge on `ack_i` does not raise `irq_o`.
- R10: `irq_o` stays high until a status read and clears at the clock edge that ends that read. If a new enabled falling edge is detected in that same cycle, the set wins and `irq_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational during a read |
| pd_o | output | 8 | Data pin drive value |
| pd_oe_o | output | 1 | Data pin driver enable |
| pd_i | input | 8 | Data pin levels |
| ctl_o | output | 4 | Control pin levels: strobe, auto feed, init, select-in |
| busy_i | input | 1 | Peripheral busy line |
| ack_i | input | 1 | Peripheral acknowledge line |
| pout_i | input | 1 | Paper-out line |
| slct_i | input | 1 | Select line |
| err_i | input | 1 | Error line |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume a bus access lasts exactly one cycle with `sel_i` high. They also assume the host never writes and reads in the same cycle, so the interrupt-clear and register-update properties each see one access per edge. The stimulus drives every bus signal on the falling clock edge and releases `sel_i` after one rising edge. It changes peripheral pins only on falling edges and waits two rising edges before sampling them through a read. The random part picks offsets, bytes and pin levels from a fixed-seed generator and stays within these rules.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned STS_N  = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd2;

  // control bit positions
  localparam int unsigned CB_DIR = 5;
  localparam int unsigned CB_IEN = 4;
  localparam int unsigned CTRL_KEEP = 6;  // bits held in storage

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h0C;
  // pins that are driven inverted relative to the control bit
  localparam logic [CTL_W-1:0] CTL_INV = 4'b1011;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_data_i,
  input  logic                 wr_ctrl_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [BYTE_W-1:0]    data_q_o,
  output logic [CTRL_KEEP-1:0] ctrl_q_o,
  output logic [CTL_W-1:0]     ctl_o
);
  logic [BYTE_W-1:0]    data_q;
  logic [CTRL_KEEP-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= CTRL_RST[CTRL_KEEP-1:0];
    end else begin
      if (wr_data_i) data_q <= wdata_i;
      if (wr_ctrl_i) ctrl_q <= wdata_i[CTRL_KEEP-1:0];
    end
  end

  for (genvar i = 0; i < CTL_W; i++) begin : g_pin
    if (CTL_INV[i]) begin : g_inv
      assign ctl_o[i] = ~ctrl_q[i];
    end else begin : g_pass
      assign ctl_o[i] = ctrl_q[i];
    end
  end

  assign data_q_o = data_q;
  assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_s_i,
  input  logic ien_i,
  input  logic clr_i,
  output logic fall_o,
  output logic irq_o
);
  logic ack_q, irq_q;

  assign fall_o = ack_q & ~ack_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      ack_q <= ack_s_i;
      // a fresh edge beats a simultaneous clear
      if (fall_o && ien_i) irq_q <= 1'b1;
      else if (clr_i)      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] pd_o,
  output logic              pd_oe_o,
  input  logic [BYTE_W-1:0] pd_i,
  output logic [CTL_W-1:0]  ctl_o,
  input  logic              busy_i,
  input  logic              ack_i,
  input  logic              pout_i,
  input  logic              slct_i,
  input  logic              err_i,
  output logic              irq_o
);
  logic [BYTE_W-1:0]    data_q, pd_s;
  logic [CTRL_KEEP-1:0] ctrl_q;
  logic [STS_N-1:0]     sts_s;
  logic                 rd_stat, ack_fall;
  logic [BYTE_W-1:0]    stat_b, ctrl_b;

  pport_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (sel_i && wr_i && addr_i == OFS_DATA),
    .wr_ctrl_i (sel_i && wr_i && addr_i == OFS_CTRL),
    .wdata_i   (wdata_i),
    .data_q_o  (data_q),
    .ctrl_q_o  (ctrl_q),
    .ctl_o     (ctl_o)
  );

  // order: busy, ack, pout, slct, err; ack idles high
  pport_sync #(.W(STS_N), .RST_VAL(5'b01000)) u_sts_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({busy_i, ack_i, pout_i, slct_i, err_i}),
    .q_o   (sts_s)
  );

  pport_sync #(.W(BYTE_W), .RST_VAL('0)) u_pd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_i),
    .q_o   (pd_s)
  );

  assign rd_stat = sel_i && !wr_i && addr_i == OFS_STAT;

  pport_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_s_i(sts_s[3]),
    .ien_i  (ctrl_q[CB_IEN]),
    .clr_i  (rd_stat),
    .fall_o (ack_fall),
    .irq_o  (irq_o)
  );

  assign stat_b = {~sts_s[4], sts_s[3:0], 2'b11, 1'b0};
  assign ctrl_b = {{(BYTE_W-CTRL_KEEP){1'b0}}, ctrl_q};

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (addr_i)
        OFS_DATA: rdata_o = ctrl_q[CB_DIR] ? pd_s : data_q;
        OFS_STAT: rdata_o = stat_b;
        OFS_CTRL: rdata_o = ctrl_b;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign pd_o    = data_q;
  assign pd_oe_o = ~ctrl_q[CB_DIR];
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] pd_o,
  input logic       pd_oe_o,
  input logic       irq_o,
  input logic       ien,
  input logic       ack_fall
);
  AST_DATA_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && wr_i && addr_i == 2'd0 |=> pd_o == $past(wdata_i)); // R3
  AST_DIR_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && wr_i && addr_i == 2'd2 && !wdata_i[5] |=> pd_oe_o); // R3
  AST_DIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && wr_i && addr_i == 2'd2 && wdata_i[5] |=> !pd_oe_o); // R4
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fall && ien |=> irq_o); // R8
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !ien |=> !irq_o); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(sel_i && !wr_i && addr_i == 2'd1) |=> irq_o); // R10
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !wr_i && addr_i == 2'd1 && !ack_fall |=> !irq_o); // R10
endmodule

bind pport_regs pport_regs_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pd_o    (pd_o),
  .pd_oe_o (pd_oe_o),
  .irq_o   (irq_o),
  .ien     (ctrl_q[4]),
  .ack_fall(ack_fall)
);

// File: tb/sim_pport_regs.sv
module sim_pport_regs;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pd_o, pd_i = 8'h00;
  logic pd_oe, irq;
  logic [3:0] ctl;
  logic busy = 0, ack = 1, pout = 0, slct = 0, err = 0;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  pport_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pd_o(pd_o), .pd_oe_o(pd_oe), .pd_i(pd_i),
    .ctl_o(ctl), .busy_i(busy), .ack_i(ack), .pout_i(pout), .slct_i(slct),
    .err_i(err), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic [7:0] c);
    return {~c[3], c[2], ~c[1], ~c[0]};
  endfunction

  function automatic logic [7:0] exp_stat(input logic b, a, p, s, e);
    return {~b, a, p, s, e, 3'b110};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 sel = 0;
  endtask

  logic [7:0] r, ctrl_m, data_m;

  initial begin
    #(CLK_P * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    #1 chk("R2 oe", {7'd0, pd_oe}, 8'h01);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    chk("R2 pins", {4'd0, ctl}, 8'h07);
    bus_rd(2'd2, r); chk("R2 ctrl", r, 8'h0C);
    bus_rd(2'd0, r); chk("R2 data", r, 8'h00);
    // R1 idle bus
    #1 chk("R1 idle rdata", rdata, 8'h00);
    // R3 directed
    bus_wr(2'd0, 8'hAA); #1 chk("R3 pd_o", pd_o, 8'hAA);
    bus_rd(2'd0, r); chk("R3 AA", r, 8'hAA);
    bus_wr(2'd0, 8'h55); bus_rd(2'd0, r); chk("R3 55", r, 8'h55);
    // R1 offset 3
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, r); chk("R1 ofs3", r, 8'h00);
    bus_rd(2'd0, r); chk("R1 ofs3 data kept", r, 8'h55);
    bus_rd(2'd2, r); chk("R1 ofs3 ctrl kept", r, 8'h0C);
    // R5 / R6
    bus_wr(2'd2, 8'h0E); bus_rd(2'd2, r); chk("R5 0E", r, 8'h0E);
    #1 chk("R5 pins", {4'd0, ctl}, {4'd0, exp_pins(8'h0E)});
    bus_wr(2'd2, 8'hC3); bus_rd(2'd2, r); chk("R6 hi bits", r, 8'h03);
    #1 chk("R6 pins", {4'd0, ctl}, {4'd0, exp_pins(8'h03)});
    chk("R6 oe", {7'd0, pd_oe}, 8'h01);
    // R4 direction
    bus_wr(2'd2, 8'h2C);
    #1 chk("R4 oe", {7'd0, pd_oe}, 8'h00);
    @(negedge clk); pd_i = 8'h3C;
    repeat (2) @(posedge clk);
    bus_rd(2'd0, r); chk("R4 pins", r, 8'h3C);
    chk("R4 latch kept", pd_o, 8'h55);
    bus_wr(2'd2, 8'h0C);
    // R7 directed
    @(negedge clk); busy = 1; ack = 1; pout = 0; slct = 1; err = 0;
    repeat (2) @(posedge clk);
    bus_rd(2'd1, r); chk("R7 status", r, exp_stat(1, 1, 0, 1, 0));
    // R9 disabled edge
    @(negedge clk); ack = 0;
    repeat (4) @(posedge clk); #1 chk("R9 no irq", {7'd0, irq}, 8'h00);
    @(negedge clk); ack = 1; repeat (3) @(posedge clk);
    // R8 enabled edge, timing
    bus_wr(2'd2, 8'h1C);
    @(negedge clk); ack = 0;
    repeat (2) @(posedge clk); #1 chk("R8 not yet", {7'd0, irq}, 8'h00);
    @(posedge clk); #1 chk("R8 set", {7'd0, irq}, 8'h01);
    // R10 hold then clear
    @(negedge clk); ack = 1;
    repeat (5) @(posedge clk); #1 chk("R10 hold", {7'd0, irq}, 8'h01);
    bus_rd(2'd2, r); #1 chk("R10 other read", {7'd0, irq}, 8'h01);
    bus_rd(2'd1, r); #1 chk("R10 clear", {7'd0, irq}, 8'h00);
    // R10 set wins over clear: fall detected at 3rd edge, read in that cycle
    @(negedge clk); ack = 0;
    @(posedge clk); @(posedge clk);
    bus_rd(2'd1, r); #1 chk("R10 set wins", {7'd0, irq}, 8'h01);
    bus_rd(2'd1, r); #1 chk("R10 clear after", {7'd0, irq}, 8'h00);
    @(negedge clk); ack = 1; repeat (3) @(posedge clk);

    // random mix
    ctrl_m = 8'h1C; data_m = 8'h55;
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) begin
        logic [7:0] d = 8'($urandom);
        bus_wr(2'd0, d); data_m = d;
        @(negedge clk); pd_i = 8'($urandom);
        repeat (2) @(posedge clk);
        bus_rd(2'd0, r);
        chk(ctrl_m[5] ? "R4 rand" : "R3 rand", r, ctrl_m[5] ? pd_i : data_m);
      end else if (op == 1) begin
        logic [7:0] c = 8'($urandom);
        bus_wr(2'd2, c); ctrl_m = c;
        bus_rd(2'd2, r); chk("R5 rand ctrl", r, {2'b00, c[5:0]});
        #1 chk("R5 rand pins", {4'd0, ctl}, {4'd0, exp_pins(c)});
        chk("R4 rand oe", {7'd0, pd_oe}, {7'd0, ~c[5]});
      end else begin
        logic [4:0] s = 5'($urandom);
        @(negedge clk); {busy, ack, pout, slct, err} = s;
        repeat (2) @(posedge clk);
        bus_rd(2'd1, r); chk("R7 rand", r, exp_stat(s[4], s[3], s[2], s[1], s[0]));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule